// File: doc/BRIEF.md
# Power-Management Register Slave with Interrupt Unit

This block is the register target behind a serial control bus endpoint. It holds thirty-two 16-bit register slots that a bus engine reaches through a simple parallel request port: one request per clock, a write committing at the rising edge and read data presented combinationally for the index being requested. The slots hold an identification word, an interrupt status and mask pair that drives a level interrupt line, a channel-indexed result bank whose reads carry the channel number, a sample-control word whose bits are cleared by writes, a calibration word, two general control words, a button status word and a watchdog slot that can raise a shutdown request.

A power-button event input sets an interrupt source and records the button level in the status word. A load port lets the surrounding environment replace stored channel results. Slots reserved for functions outside this block read as zero and ignore writes. Indices that name no slot at all raise a sticky access-error flag.

Top module: `pmr_regslave`

## Requirements
- R1: Index 0x00 reads 0x0215, with bit 7 also set while `variant_sel` is high; writes to it change nothing.
- R2: Interrupt status resets to 0x0000; a write to index 0x01 XORs the written value into it, and a read of 0x01 returns it.
- R3: The interrupt mask at index 0x02 resets to 0xFFFF and is plain read/write; `irq_out` is high exactly when some status bit is set whose mask bit is clear.
- R4: A read of index 0x08 returns the selected channel number in bits [13:10] ORed with that channel's 10-bit result in bits [9:0]; a write to 0x08 selects the channel from bits [13:10] of the data and sets status bit 8. The selected channel resets to 0.
- R5: Channel results reset to 0x3C2, 0x0FC, 0x165, 0x07B, 0x3FF, 0x011, 0x011, 0x250 for channels 1 to 8, 0x002, 0x011, 0x3D0, 0x330 for channels 10 to 13, and zero elsewhere; a load-port strobe overwrites the addressed channel's result.
- R6: The sample-control word at index 0x09 resets to parameter `SCTL_INIT` (0x00FF); a write clears each bit that is set in the written value and leaves the others.
- R7: Writing 0x0000 to index 0x17 while bit 1 of the control word at 0x0D is set raises `shutdown_req`, which stays high until reset; any other write to 0x17 has no effect.
- R8: A `btn_event` pulse sets status bit 0 and sets bit 5 of the status word at index 0x16 to the inverse of `btn_level` (1 = pressed); that word resets to 0x0020 and is read-only. An event in the same cycle as a status write leaves bit 0 set.
- R9: The calibration word at 0x06 resets to 0x0001; the control words at 0x0D and 0x0E reset to zero; all three are plain read/write.
- R10: Indices 0x03-0x05, 0x0A-0x0C, 0x0F-0x11 and 0x18-0x1F, and 0x17 on read, return zero; writes to them change no observable state.
- R11: Indices 0x07 and 0x12-0x15 read zero, ignore writes, and any access to them sets `access_err`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| variant_sel | input | 1 | Selects the alternate identification value |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 5 | Register index |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data for `req_index`, combinational |
| btn_event | input | 1 | One-cycle power-button event strobe |
| btn_level | input | 1 | Button level at the event, 1 = pressed |
| res_load_en | input | 1 | Channel result load strobe |
| res_load_ch | input | 4 | Channel to load |
| res_load_val | input | 10 | Result value to store |
| irq_out | output | 1 | Level interrupt, unmasked status pending |
| shutdown_req | output | 1 | Sticky shutdown request |
| access_err | output | 1 | Sticky undefined-index access flag |

## Verification
The register file is driven with random indices over all thirty-two slots and random data, interleaved with button events and result loads, so that the XOR status path, the clear-on-write sample word and the mask are each exercised against a wide spread of prior values; mismatches there separate XOR from plain or set-only write behaviour. Directed cases read every reset value, tag-and-result reads on several channels, the identification variant, a status write that coincides with a button event, the watchdog write with the control bit clear and set, and accesses to undefined indices, which distinguish a stub slot from an error slot. After every operation the interrupt, shutdown and error outputs are compared against a bench model.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    localparam int REG_W      = 16;
    localparam int IDX_W      = 5;
    localparam int CH_W       = 4;
    localparam int RES_W      = 10;
    localparam int NCH        = 1 << CH_W;
    localparam int CH_LSB     = 10;

    localparam logic [REG_W-1:0] ID_BASE  = 16'h0215;
    localparam int               ID_VBIT  = 7;
    localparam logic [REG_W-1:0] STAT_RST = 16'h0020;
    localparam logic [REG_W-1:0] CAL_RST  = 16'h0001;

    localparam int IRQ_BTN      = 0;
    localparam int IRQ_SAMPLE   = 8;
    localparam int STAT_BTN_BIT = 5;
    localparam int CC_WDOG_BIT  = 1;

    typedef enum logic [3:0] {
        K_ID, K_IST, K_IMSK, K_CAL, K_CHAN, K_SCTL,
        K_CC1, K_CC2, K_STAT, K_WDOG, K_ZERO, K_BAD
    } reg_kind_e;

    function automatic reg_kind_e classify(input logic [IDX_W-1:0] idx);
        case (idx)
            5'h00:                      return K_ID;
            5'h01:                      return K_IST;
            5'h02:                      return K_IMSK;
            5'h06:                      return K_CAL;
            5'h08:                      return K_CHAN;
            5'h09:                      return K_SCTL;
            5'h0D:                      return K_CC1;
            5'h0E:                      return K_CC2;
            5'h16:                      return K_STAT;
            5'h17:                      return K_WDOG;
            5'h07, 5'h12, 5'h13,
            5'h14, 5'h15:               return K_BAD;
            default:                    return K_ZERO;
        endcase
    endfunction

    function automatic logic [RES_W-1:0] chan_default(input int unsigned ch);
        case (ch)
            1:       return 10'h3C2;
            2:       return 10'h0FC;
            3:       return 10'h165;
            4:       return 10'h07B;
            5:       return 10'h3FF;
            6, 7:    return 10'h011;
            8:       return 10'h250;
            10:      return 10'h002;
            11:      return 10'h011;
            12:      return 10'h3D0;
            13:      return 10'h330;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/pmr_decode.sv
module pmr_decode
    import pmr_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output reg_kind_e        kind
);
    always_comb kind = classify(idx);
endmodule

// File: rtl/pmr_irq_unit.sv
module pmr_irq_unit #(
    parameter int W = 16,
    parameter int BTN_BIT = 0,
    parameter int SAMPLE_BIT = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         st_wr,
    input  logic         mask_wr,
    input  logic [W-1:0] wdata,
    input  logic         sample_set,
    input  logic         btn_set,
    output logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         irq
);
    logic [W-1:0] st_q, mask_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_wr)      st_d = st_d ^ wdata;
        if (sample_set) st_d[SAMPLE_BIT] = 1'b1;
        if (btn_set)    st_d[BTN_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            mask_q <= '1;
        end else begin
            st_q <= st_d;
            if (mask_wr) mask_q <= wdata;
        end
    end

    assign status = st_q;
    assign mask   = mask_q;
    assign irq    = |(st_q & ~mask_q);

    // R3
    full_mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_wr && wdata == '1) |=> !irq);
    // R8
    btn_sets_src_chk: assert property (@(posedge clk) disable iff (rst)
        btn_set |=> status[BTN_BIT]);
    // R4
    sample_sets_src_chk: assert property (@(posedge clk) disable iff (rst)
        sample_set |=> status[SAMPLE_BIT]);
    // R2
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!st_wr && !sample_set && !btn_set) |=> $stable(status));
endmodule

// File: rtl/pmr_chan_bank.sv
module pmr_chan_bank
    import pmr_pkg::*;
#(
    parameter int N  = NCH,
    parameter int CW = CH_W,
    parameter int RW = RES_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_we,
    input  logic [CW-1:0] sel_ch,
    input  logic          ld_en,
    input  logic [CW-1:0] ld_ch,
    input  logic [RW-1:0] ld_val,
    output logic [CW-1:0] cur_ch,
    output logic [RW-1:0] cur_res
);
    logic [RW-1:0] res_q [N];
    logic [CW-1:0] ch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) res_q[i] <= chan_default(i);
            ch_q <= '0;
        end else begin
            for (int i = 0; i < N; i++)
                if (ld_en && ld_ch == CW'(i)) res_q[i] <= ld_val;
            if (sel_we) ch_q <= sel_ch;
        end
    end

    assign cur_ch  = ch_q;
    assign cur_res = res_q[ch_q];

    // R4
    chan_select_chk: assert property (@(posedge clk) disable iff (rst)
        sel_we |=> cur_ch == $past(sel_ch));
    // R5
    load_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_en && !sel_we && ld_ch == cur_ch) |=> cur_res == $past(ld_val));
endmodule

// File: rtl/pmr_regslave.sv
module pmr_regslave
    import pmr_pkg::*;
#(
    parameter logic [15:0] SCTL_INIT = 16'h00FF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        variant_sel,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [4:0]  req_index,
    input  logic [15:0] req_wdata,
    output logic [15:0] rsp_rdata,
    input  logic        btn_event,
    input  logic        btn_level,
    input  logic        res_load_en,
    input  logic [3:0]  res_load_ch,
    input  logic [9:0]  res_load_val,
    output logic        irq_out,
    output logic        shutdown_req,
    output logic        access_err
);
    reg_kind_e        kind;
    logic             wr;
    logic [REG_W-1:0] st, msk, cal_q, cc1_q, cc2_q, sctl_q, stat_q;
    logic             shut_q, err_q;
    logic [CH_W-1:0]  cur_ch;
    logic [RES_W-1:0] cur_res;

    pmr_decode u_dec (.idx(req_index), .kind(kind));

    assign wr = req_valid && req_write;

    pmr_irq_unit #(.W(REG_W), .BTN_BIT(IRQ_BTN), .SAMPLE_BIT(IRQ_SAMPLE)) u_irq (
        .clk(clk), .rst(rst),
        .st_wr(wr && kind == K_IST),
        .mask_wr(wr && kind == K_IMSK),
        .wdata(req_wdata),
        .sample_set(wr && kind == K_CHAN),
        .btn_set(btn_event),
        .status(st), .mask(msk), .irq(irq_out)
    );

    pmr_chan_bank u_bank (
        .clk(clk), .rst(rst),
        .sel_we(wr && kind == K_CHAN),
        .sel_ch(req_wdata[CH_LSB +: CH_W]),
        .ld_en(res_load_en), .ld_ch(res_load_ch), .ld_val(res_load_val),
        .cur_ch(cur_ch), .cur_res(cur_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q  <= CAL_RST;
            cc1_q  <= '0;
            cc2_q  <= '0;
            sctl_q <= SCTL_INIT;
            stat_q <= STAT_RST;
            shut_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (wr) begin
                case (kind)
                    K_CAL:  cal_q  <= req_wdata;
                    K_CC1:  cc1_q  <= req_wdata;
                    K_CC2:  cc2_q  <= req_wdata;
                    K_SCTL: sctl_q <= sctl_q & ~req_wdata;
                    K_WDOG: if (req_wdata == '0 && cc1_q[CC_WDOG_BIT]) shut_q <= 1'b1;
                    default: ;
                endcase
            end
            if (req_valid && kind == K_BAD) err_q <= 1'b1;
            if (btn_event) stat_q[STAT_BTN_BIT] <= ~btn_level;
        end
    end

    always_comb begin
        case (kind)
            K_ID:    rsp_rdata = ID_BASE | (REG_W'(variant_sel) << ID_VBIT);
            K_IST:   rsp_rdata = st;
            K_IMSK:  rsp_rdata = msk;
            K_CAL:   rsp_rdata = cal_q;
            K_CHAN:  rsp_rdata = (REG_W'(cur_ch) << CH_LSB) | REG_W'(cur_res);
            K_SCTL:  rsp_rdata = sctl_q;
            K_CC1:   rsp_rdata = cc1_q;
            K_CC2:   rsp_rdata = cc2_q;
            K_STAT:  rsp_rdata = stat_q;
            default: rsp_rdata = '0;
        endcase
    end

    assign shutdown_req = shut_q;
    assign access_err   = err_q;

    // R7
    shutdown_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(shut_q) |-> shut_q);
    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(err_q) |-> err_q);
    // R6
    sctl_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && kind == K_SCTL) |=> (sctl_q & $past(req_wdata)) == '0);
    // R8
    stat_readonly_chk: assert property (@(posedge clk) disable iff (rst)
        !btn_event |=> $stable(stat_q));
endmodule

// File: tb/pmr_regslave_tb.sv
`timescale 1ns/1ps
module pmr_regslave_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        variant_sel = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]  req_index = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rsp_rdata;
    logic        btn_event = 1'b0, btn_level = 1'b0;
    logic        res_load_en = 1'b0;
    logic [3:0]  res_load_ch = '0;
    logic [9:0]  res_load_val = '0;
    logic        irq_out, shutdown_req, access_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [15:0] SCTL_INIT = 16'h00FF;

    pmr_regslave #(.SCTL_INIT(SCTL_INIT)) u_dut (.*);

    always #4 clk = ~clk;

    // bench model
    logic [15:0] m_st, m_mask, m_cal, m_cc1, m_cc2, m_sctl, m_stat;
    logic [3:0]  m_ch;
    logic [9:0]  m_res [16];
    bit          m_shut, m_err;

    function automatic logic [9:0] res_init(input int c);
        logic [9:0] t [16] = '{10'h000, 10'h3C2, 10'h0FC, 10'h165, 10'h07B, 10'h3FF,
                               10'h011, 10'h011, 10'h250, 10'h000, 10'h002, 10'h011,
                               10'h3D0, 10'h330, 10'h000, 10'h000};
        return t[c];
    endfunction

    function automatic bit is_bad(input logic [4:0] i);
        return (i == 5'h07) || (i >= 5'h12 && i <= 5'h15);
    endfunction

    function automatic logic [15:0] exp_read(input logic [4:0] i);
        case (i)
            5'h00: return 16'h0215 | (variant_sel ? 16'h0080 : 16'h0000);
            5'h01: return m_st;
            5'h02: return m_mask;
            5'h06: return m_cal;
            5'h08: return {2'b00, m_ch, m_res[m_ch]};
            5'h09: return m_sctl;
            5'h0D: return m_cc1;
            5'h0E: return m_cc2;
            5'h16: return m_stat;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model_reset();
        m_st = 0; m_mask = 16'hFFFF; m_cal = 16'h0001; m_cc1 = 0; m_cc2 = 0;
        m_sctl = SCTL_INIT; m_stat = 16'h0020; m_ch = 0; m_shut = 0; m_err = 0;
        for (int c = 0; c < 16; c++) m_res[c] = res_init(c);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %04h expected %04h", tag, act, exp);
        end
    endtask

    task automatic chk_outs(input string tag);
        chk({tag, " irq R3"}, 16'(irq_out), 16'(|(m_st & ~m_mask)));
        chk({tag, " shutdown R7"}, 16'(shutdown_req), 16'(m_shut));
        chk({tag, " err R11"}, 16'(access_err), 16'(m_err));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // one request, optional simultaneous button event; call at a negedge
    task automatic op(input string tag, input bit w, input logic [4:0] idx,
                      input logic [15:0] v, input bit be, input bit bl);
        logic [15:0] ex;
        req_valid = 1'b1; req_write = w; req_index = idx; req_wdata = v;
        btn_event = be; btn_level = bl;
        #2;
        if (!w) begin
            ex = exp_read(idx);
            chk({tag, " read"}, rsp_rdata, ex);
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; btn_event = 1'b0;
        if (is_bad(idx)) m_err = 1;
        if (w) begin
            case (idx)
                5'h01: m_st = m_st ^ v;
                5'h02: m_mask = v;
                5'h06: m_cal = v;
                5'h08: begin m_ch = v[13:10]; m_st[8] = 1'b1; end
                5'h09: m_sctl = m_sctl & ~v;
                5'h0D: m_cc1 = v;
                5'h0E: m_cc2 = v;
                5'h17: if (v == 16'h0000 && m_cc1[1]) m_shut = 1;
                default: ;
            endcase
        end
        if (be) begin
            m_st[0] = 1'b1;
            m_stat[5] = ~bl;
        end
        chk_outs(tag);
    endtask

    task automatic load(input logic [3:0] c, input logic [9:0] v);
        res_load_en = 1'b1; res_load_ch = c; res_load_val = v;
        @(negedge clk);
        res_load_en = 1'b0;
        m_res[c] = v;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5EED_1234);
        @(negedge clk);
        do_reset();

        // reset state
        chk_outs("reset");
        op("R1 id", 0, 5'h00, 0, 0, 0);
        op("R2 status reset", 0, 5'h01, 0, 0, 0);
        op("R3 mask reset", 0, 5'h02, 0, 0, 0);
        op("R9 cal reset", 0, 5'h06, 0, 0, 0);
        op("R9 cc1 reset", 0, 5'h0D, 0, 0, 0);
        op("R6 sctl reset", 0, 5'h09, 0, 0, 0);
        op("R8 stat reset", 0, 5'h16, 0, 0, 0);
        op("R4 chan0 reset", 0, 5'h08, 0, 0, 0);

        // R1 variant and read-only
        variant_sel = 1'b1;
        op("R1 variant", 0, 5'h00, 0, 0, 0);
        op("R1 write", 1, 5'h00, 16'hFFFF, 0, 0);
        op("R1 after write", 0, 5'h00, 0, 0, 0);
        variant_sel = 1'b0;

        // R4/R5 channel select and tags
        op("R4 sel1", 1, 5'h08, 16'h0400, 0, 0);
        op("R5 ch1", 0, 5'h08, 0, 0, 0);
        op("R4 status bit8", 0, 5'h01, 0, 0, 0);
        op("R3 unmask bit8", 1, 5'h02, 16'hFEFF, 0, 0);
        op("R2 xor clear", 1, 5'h01, 16'h0100, 0, 0);
        op("R4 sel13", 1, 5'h08, 16'hF7FF & 16'h3400, 0, 0);
        op("R5 ch13", 0, 5'h08, 0, 0, 0);
        op("R4 sel12", 1, 5'h08, 16'h3000, 0, 0);
        op("R5 ch12", 0, 5'h08, 0, 0, 0);
        load(4'd12, 10'h155);
        op("R5 ch12 loaded", 0, 5'h08, 0, 0, 0);

        // R6
        op("R6 clear low", 1, 5'h09, 16'h000F, 0, 0);
        op("R6 sctl", 0, 5'h09, 0, 0, 0);

        // R8 button
        op("R8 press", 0, 5'h16, 0, 1, 1);
        op("R8 stat pressed", 0, 5'h16, 0, 0, 0);
        op("R8 release", 0, 5'h01, 0, 1, 0);
        op("R8 stat released", 0, 5'h16, 0, 0, 0);
        op("R8 write stat ignored", 1, 5'h16, 16'h0000, 0, 0);
        op("R8 stat kept", 0, 5'h16, 0, 0, 0);
        op("R8 xor with event", 1, 5'h01, 16'h0001, 1, 1);
        op("R8 bit0 kept", 0, 5'h01, 0, 0, 0);

        // R10 stub slots
        op("R10 stub write", 1, 5'h0A, 16'hABCD, 0, 0);
        op("R10 stub read", 0, 5'h0A, 0, 0, 0);
        op("R10 cc1 untouched", 0, 5'h0D, 0, 0, 0);
        op("R10 wdog read", 0, 5'h17, 0, 0, 0);

        // R7 watchdog
        op("R7 zero no enable", 1, 5'h17, 16'h0000, 0, 0);
        op("R9 cc1 write", 1, 5'h0D, 16'h0002, 0, 0);
        op("R7 nonzero", 1, 5'h17, 16'h0001, 0, 0);
        op("R7 zero enabled", 1, 5'h17, 16'h0000, 0, 0);
        op("R7 sticky", 1, 5'h0D, 16'h0000, 0, 0);

        // R11 undefined
        op("R11 bad read", 0, 5'h07, 0, 0, 0);
        op("R11 bad write", 1, 5'h12, 16'h1234, 0, 0);
        op("R11 bad read2", 0, 5'h12, 0, 0, 0);

        // random phase from fresh reset
        do_reset();
        chk_outs("R2 rereset");
        for (int n = 0; n < 1500; n++) begin
            int r;
            logic [4:0] idx;
            logic [15:0] v;
            r = int'($urandom % 16);
            idx = 5'($urandom);
            v = 16'($urandom);
            if ($urandom % 8 == 0) v = 16'h0000;
            if (r == 0) load(4'($urandom), 10'($urandom));
            else if (r < 3) op("R8 rnd event", 0, idx, 0, 1, 1'($urandom));
            else if (r < 9) op("R2 rnd write", 1, idx, v, 0, 0);
            else op("R4 rnd read", 0, idx, 0, 0, 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule